// File: doc/BRIEF.md
# Transmit Loopback Carrier-Loss Monitor

While a frame is being sent through a port whose transceiver echoes the transmit data back, this block watches the carrier-sense signal recovered from that echo. The echo is the evidence that the path to and from the transceiver works. The block raises a loss-of-carrier error in two cases. The first is when the echo fails to appear within a programmable number of bit times after transmission begins. The second is when the echo appears and then disappears while the frame is still going out.

The verdict is held back while the frame is in flight. After the transmit logic signals that the frame is complete, the block issues a one-cycle status-valid pulse, and the error flag takes its final value in that same cycle. The flag keeps that value until the next transmission begins. The check is armed only when the echoing port is the selected port, and the selection is sampled when the transmission starts.

Top module: `txcar_monitor`

## Requirements
- R1: After reset, `lcar_err` and `status_vld` are both 0.
- R2: Transmission start is the first cycle with `tx_active` high after a cycle with it low. Counting from that start, `carrier` must be high on or before the (D+1)-th cycle in which `bit_tick` and `tx_active` are both high, where D is the value of `deadline`. Otherwise the frame is in error. With D = 0, carrier must be present by the first tick.
- R3: A frame in which `carrier` is never high while `tx_active` is high is in error, even when the frame ends before the deadline tick.
- R4: A frame is in error when `carrier` is low in a cycle where `tx_active` is high, after carrier has been seen in that transmission. Carrier falling in the same cycle that `tx_active` falls is not an error.
- R5: `status_vld` is high for exactly the one cycle after a cycle with `frame_done` high. `lcar_err` changes from 0 to 1 only in that cycle, so it never reports during a frame.
- R6: When `port_sel` is 0 in the start cycle of a transmission, that frame reports `lcar_err` = 0.
- R7: `lcar_err` is cleared to 0 in the cycle after each transmission start. The error state of an earlier frame never carries into a later one.
- R8: A frame whose carrier is high from the first tick until `tx_active` falls reports `lcar_err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | Echoing port is selected; sampled at transmission start |
| tx_active | input | 1 | High while a frame is being transmitted |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| carrier | input | 1 | Carrier sense recovered from the looped-back data |
| frame_done | input | 1 | Pulse after the frame has been completely sent |
| deadline | input | 8 | Ticks allowed before carrier must appear (0 = by first tick) |
| lcar_err | output | 1 | Loss-of-carrier verdict of the last reported frame |
| status_vld | output | 1 | One-cycle pulse when `lcar_err` holds its final value |

## Verification
The bench places carrier arrival exactly on the deadline tick and one tick past it, with a deadline of zero and a non-zero deadline. A design that is off by one in its tick count passes late frames or fails good ones. Frames shorter than the deadline with no carrier catch a design that only reports on the deadline tick and so misses silent short frames. Carrier is dropped in the same cycle as transmit ends, which catches a design that calls a normal end an early drop, and carrier is also dropped mid-frame. An error frame is followed by a clean one to expose a verdict that fails to clear. A deselected port is run with a silent frame. The bench also checks that the flag stays low before the report and that the valid pulse comes exactly one cycle after frame completion, so an early report or a misplaced pulse is caught.

// File: rtl/txcm_pkg.sv
package txcm_pkg;
  localparam int DL_W = 8;

  // Count of ticks since start, one bit wider than the deadline so it can
  // pass the deadline and stop there.
  function automatic logic [DL_W:0] sat_inc(input logic [DL_W:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  // The tick at which carrier is due is the one whose prior count equals D.
  function automatic logic tick_is_due(input logic [DL_W:0] cnt,
                                       input logic [DL_W-1:0] dl);
    return cnt == {1'b0, dl};
  endfunction
endpackage

// File: rtl/txcm_deadline.sv
module txcm_deadline
  import txcm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tx_active,
  input  logic            bit_tick,
  input  logic            seen_now,
  input  logic [DL_W-1:0] deadline,
  output logic            miss
);
  logic [DL_W:0] cnt, cnt_cur;
  logic          tick_run;

  assign cnt_cur  = start ? '0 : cnt;
  assign tick_run = tx_active & bit_tick;
  assign miss     = tick_run & tick_is_due(cnt_cur, deadline) & ~seen_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (tick_run)
      cnt <= sat_inc(cnt_cur);
    else if (start)
      cnt <= '0;
  end

  // R2: a miss can only be declared on a counted tick of an active frame
  a_r2_miss_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (bit_tick && tx_active && !seen_now));
endmodule

// File: rtl/txcm_track.sv
module txcm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tx_active,
  input  logic tx_q,
  input  logic carrier,
  output logic seen_now,
  output logic drop_evt,
  output logic unseen_end
);
  logic seen, seen_prev;

  assign seen_prev  = start ? 1'b0 : seen;
  assign seen_now   = seen_prev | (tx_active & carrier);
  assign drop_evt   = tx_active & seen_prev & ~carrier;
  assign unseen_end = tx_q & ~tx_active & ~seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen <= 1'b0;
    else if (tx_active)
      seen <= seen_now;
  end

  // R4: an early drop is only ever declared while the frame is still active
  a_r4_drop_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (tx_active && !carrier));
endmodule

// File: rtl/txcm_report.sv
module txcm_report (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic port_sel,
  input  logic miss,
  input  logic drop_evt,
  input  logic unseen_end,
  input  logic frame_done,
  output logic err_pend,
  output logic armed,
  output logic lcar_err,
  output logic status_vld
);
  logic err_n, armed_cur;

  assign err_n     = (start ? 1'b0 : err_pend) | miss | drop_evt | unseen_end;
  assign armed_cur = start ? port_sel : armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pend   <= 1'b0;
      armed      <= 1'b0;
      lcar_err   <= 1'b0;
      status_vld <= 1'b0;
    end else begin
      err_pend   <= err_n;
      armed      <= armed_cur;
      status_vld <= frame_done;
      if (start)
        lcar_err <= 1'b0;
      else if (frame_done)
        lcar_err <= armed_cur & err_n;
    end
  end

  // R5: the verdict may only rise in the report cycle
  a_r5_rise_at_report: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcar_err) |-> (status_vld && $past(frame_done)));
  // R5: the valid pulse follows frame completion by one cycle
  a_r5_vld_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    status_vld |-> $past(frame_done));
  // R6: a frame begun on a deselected port never reports an error
  a_r6_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld && !armed) |-> !lcar_err);
  // R7: the verdict is cleared by each new transmission
  a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !lcar_err);
endmodule

// File: rtl/txcar_monitor.sv
module txcar_monitor
  import txcm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_sel,
  input  logic            tx_active,
  input  logic            bit_tick,
  input  logic            carrier,
  input  logic            frame_done,
  input  logic [DL_W-1:0] deadline,
  output logic            lcar_err,
  output logic            status_vld
);
  logic tx_q, start;
  logic seen_now, drop_evt, unseen_end, miss;
  logic err_pend, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_active;
  end
  assign start = tx_active & ~tx_q;

  txcm_track u_track (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_active(tx_active),
    .tx_q(tx_q), .carrier(carrier), .seen_now(seen_now),
    .drop_evt(drop_evt), .unseen_end(unseen_end)
  );

  txcm_deadline u_dl (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_active(tx_active),
    .bit_tick(bit_tick), .seen_now(seen_now), .deadline(deadline),
    .miss(miss)
  );

  txcm_report u_rep (
    .clk(clk), .rst_n(rst_n), .start(start), .port_sel(port_sel),
    .miss(miss), .drop_evt(drop_evt), .unseen_end(unseen_end),
    .frame_done(frame_done), .err_pend(err_pend), .armed(armed),
    .lcar_err(lcar_err), .status_vld(status_vld)
  );

  // R2: a deadline miss is latched into the pending error
  a_r2_miss_latched: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> err_pend);
  // R4: an early drop is latched into the pending error
  a_r4_drop_latched: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> err_pend);
  // R3: a frame ending with no carrier seen is latched as an error
  a_r3_unseen_latched: assert property (@(posedge clk) disable iff (!rst_n)
    unseen_end |=> err_pend);
endmodule

// File: tb/sim_txcar_monitor.sv
module sim_txcar_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_sel = 1'b0, tx_active = 1'b0, bit_tick = 1'b0;
  logic       carrier = 1'b0, frame_done = 1'b0;
  logic [7:0] deadline = 8'd0;
  logic       lcar_err, status_vld;

  int  n_chk = 0, n_bad = 0;
  bit  exp_q[$];
  logic fd_seen = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  txcar_monitor u0 (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .tx_active(tx_active),
    .bit_tick(bit_tick), .carrier(carrier), .frame_done(frame_done),
    .deadline(deadline), .lcar_err(lcar_err), .status_vld(status_vld)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Monitor: pulse placement (R5) and scoreboard pop of the verdict
  always @(posedge clk) fd_seen <= frame_done;
  always @(negedge clk) begin
    if (rst_n && (status_vld || fd_seen)) begin
      check("R5 status_vld timing", status_vld, fd_seen);
      if (status_vld && exp_q.size() > 0) begin
        bit e;
        e = exp_q.pop_front();
        check("R2/R3/R4/R6/R8 lcar_err verdict", lcar_err, e);
      end
    end
  end

  // Driver: one frame of n ticks; carrier high for ticks on..off-1
  task automatic frame(input string tag, input bit sel, input int dl,
                       input int n, input int on, input int off);
    bit exp_miss, exp_drop, exp_never, exp;
    exp_miss  = (n >= dl + 1) && (on > dl + 1);
    exp_never = (on > n) || (off <= on);
    exp_drop  = !exp_never && (off <= n);
    exp       = sel && (exp_miss || exp_drop || exp_never);
    @(negedge clk);
    port_sel = sel; deadline = 8'(dl); tx_active = 1'b1;
    @(negedge clk);
    check({"R7 cleared at start ", tag}, lcar_err, 1'b0);
    for (int k = 1; k <= n; k++) begin
      carrier  = (k >= on) && (k < off);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      @(negedge clk);
    end
    tx_active = 1'b0; carrier = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({"R5 no verdict before report ", tag}, lcar_err, 1'b0);
    exp_q.push_back(exp);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset lcar_err", lcar_err, 1'b0);
    check("R1 reset status_vld", status_vld, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    frame("R8 full carrier",          1, 3, 10, 1, 11);
    frame("R3 never present",         1, 3, 10, 11, 11);
    frame("R7 clean after error",     1, 3, 10, 1, 11);
    frame("R2 late arrival",          1, 2, 10, 5, 11);
    frame("R2 on deadline tick",      1, 3, 10, 4, 11);
    frame("R2 one past deadline",     1, 3, 10, 5, 11);
    frame("R2 zero deadline ok",      1, 0, 6, 1, 7);
    frame("R2 zero deadline late",    1, 0, 6, 2, 7);
    frame("R4 mid-frame drop",        1, 3, 10, 1, 6);
    frame("R4 drop on last tick",     1, 3, 10, 1, 10);
    frame("R3 short silent frame",    1, 9, 4, 5, 5);
    frame("R8 short frame ok",        1, 9, 4, 2, 5);
    frame("R6 deselected silent",     0, 3, 10, 11, 11);
    frame("R6 deselected drop",       0, 3, 10, 1, 6);
    check("R5 scoreboard drained", exp_q.size() == 0, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule